// File: doc/BRIEF.md
# Cubic Interpolating Fractional Resampler

This block takes one signed sample per clock and produces a stream at a lower, finely selectable rate. For each output it places a point at a fractional offset t between two input samples and evaluates a third-degree polynomial in t. The polynomial coefficients are weighted sums of four neighbouring samples: one before the interval, its two ends, and one after it. A mode pin selects between two kernels. One passes exactly through all four samples. The other passes through the two interval ends and matches slopes estimated by central differences.

The offset t comes from a phase accumulator that adds a programmed step on every clock. The step is the ratio of output period to input period, minus one, as a 16-bit fraction. When the accumulator reaches one or more, that clock gives no output. On the following clock the accumulator drops by one instead of advancing. A strobe marks the clocks that carry a fresh result. The strobe is delayed through the pipeline together with its data.

The evaluation is a multiply-add chain in nested form with one register per step. The final value is scaled and clamped back to the sample width.

Top module: `cubic_resampler`

## Requirements
- R1: While reset is asserted at a rising edge, the next cycle shows `dout` = 0 and `dout_valid` = 0.
- R2: `din` is captured on every clock out of reset. No strobe appears until four samples are held. With the phase at zero, the first strobe follows the 9th rising edge after reset release, counting the first edge that sees `rst_n` high as edge 1.
- R3: A result is computed from the window and phase held before rising edge k. It appears on the outputs after edge k+4.
- R4: The phase starts at 0 and holds while the window fills. On each later clock with phase below one, that clock is evaluated at t = phase/65536 and the phase then grows by `step`.
- R5: On a clock whose phase is one or more, no strobe is produced for that position. The next phase is the old phase minus one, with no step added. Two consecutive positions are never both skipped.
- R6: `mode` = 0 selects the four-point exact-fit kernel. Scaled by 6, with xm, x0, x1, x2 = x(n−1), x(n), x(n+1), x(n+2), its coefficients are: c1 = 6·x0, c2 = −2xm −3x0 +6x1 −x2, c3 = 3xm −6x0 +3x1, c4 = −xm +3x0 −3x1 +x2.
- R7: `mode` = 1 selects the slope-matched kernel. Scaled by 6, its coefficients are: c1 = 6·x0, c2 = 3(x1 − xm), c3 = 3(2xm −5x0 +4x1 −x2), c4 = 3(−xm +3x0 −3x1 +x2).
- R8: With T = t·65536, the value is h = ⌊(⌊(⌊c4·T/65536⌋ + c3)·T/65536⌋ + c2)·T/65536⌋ + c1. The result is h/6, truncated toward zero.
- R9: A result above 127 is output as 127, and one below −128 as −128.
- R10: With `step` = 0 the phase stays at zero, and every result equals x(n) exactly.
- R11: `mode` changes only while reset is asserted.
- R12: On clocks without a strobe, `dout` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode | input | 1 | Kernel select: 0 exact fit, 1 slope matched |
| step | input | 16 | Phase increment, output/input period ratio minus one, unsigned fraction |
| din | input | 8 | Input sample, signed, one per clock |
| dout | output | 8 | Resampled value, signed |
| dout_valid | output | 1 | High for one clock per fresh result |

## Verification
Each result is due on the fifth rising edge, counting the edge at which its window and phase were held, and the first strobe is due on the ninth edge after reset release. The bench keeps its own window and phase, computes each result from them at that edge, and holds the results in a five-deep queue. It compares the oldest entry with the outputs at the falling edge, where every register involved has settled. Skip positions, held data between strobes and clamped values are all checked on the same per-clock comparison, under stimulus with step zero, mid-range and maximal steps, and steps that change while running.

// File: rtl/rsmp_pkg.sv
// Shared definitions for the cubic resampler: kernel encoding and the
// fixed structural counts of a third-degree, four-sample interpolator.
package rsmp_pkg;
    typedef enum logic {
        KERNEL_EXACT = 1'b0,
        KERNEL_SLOPE = 1'b1
    } kernel_e;

    localparam int TAPS   = 4;  // samples in the window
    localparam int NST    = 3;  // multiply-add steps of the nested evaluation
    localparam int SCALE  = 6;  // common denominator of both kernels
endpackage

// File: rtl/rsmp_window.sv
// Sample window: shifts one sample in per clock and reports when it holds
// a full set. Element 0 is the newest sample, element TAPS-1 the oldest.
// Assumes a sample is presented on every clock out of reset.
module rsmp_window
    import rsmp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] din,
    output logic signed [DW-1:0] win [TAPS],
    output logic                 full
);
    localparam int FW = $clog2(TAPS + 1);

    logic [FW-1:0] fill;

    // shift the newest sample in and age the rest
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TAPS; i++) win[i] <= '0;
        end else begin
            win[0] <= din;
            for (int i = 1; i < TAPS; i++) win[i] <= win[i-1];
        end
    end

    // count held samples up to a full window
    always_ff @(posedge clk) begin
        if (!rst_n)
            fill <= '0;
        else if (fill != FW'(TAPS))
            fill <= fill + 1'b1;
    end

    assign full = (fill == FW'(TAPS));
endmodule

// File: rtl/rsmp_phase.sv
// Phase accumulator: holds the fractional position with one integer bit.
// While the integer bit is clear, it adds the step. While it is set, it drops
// by one instead. Assumes step is below one, so a drop always clears the bit.
module rsmp_phase #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    input  logic [TW-1:0] step,
    output logic [TW-1:0] frac,
    output logic          over
);
    logic [TW:0] acc;

    // advance or renormalise the position once the window is full
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc <= '0;
        else if (advance) begin
            if (acc[TW])
                acc <= {1'b0, acc[TW-1:0]};
            else
                acc <= acc + {1'b0, step};
        end
    end

    assign frac = acc[TW-1:0];
    assign over = acc[TW];
endmodule

// File: rtl/rsmp_coef.sv
// Coefficient combiner: forms the four polynomial coefficients, scaled by
// the common denominator, from the window for the selected kernel. It
// registers them with the position and a valid flag. c4 leaves on its own
// port as the seed of the nested evaluation; c1..c3 leave as an array.
module rsmp_coef
    import rsmp_pkg::*;
#(
    parameter int DW = 8,
    parameter int TW = 16,
    parameter int AW = DW + 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode,
    input  logic signed [DW-1:0] win [TAPS],
    input  logic [TW-1:0]        t_in,
    input  logic                 v_in,
    output logic signed [AW-1:0] c_top,
    output logic signed [AW-1:0] c_low [NST],
    output logic [TW-1:0]        t_out,
    output logic                 v_out
);
    function automatic logic signed [AW-1:0] mulk(input logic signed [AW-1:0] x, input int k);
        return AW'(x * k);
    endfunction

    logic signed [AW-1:0] xm, x0, x1, x2;
    logic signed [AW-1:0] k1, k2, k3, k4;

    // weighted sums of the window for the chosen kernel
    always_comb begin
        xm = AW'(win[3]);
        x0 = AW'(win[2]);
        x1 = AW'(win[1]);
        x2 = AW'(win[0]);
        k1 = mulk(x0, 6);
        if (kernel_e'(mode) == KERNEL_SLOPE) begin
            k2 = mulk(x1 - xm, 3);
            k3 = mulk(mulk(xm, 2) - mulk(x0, 5) + mulk(x1, 4) - x2, 3);
            k4 = mulk(mulk(x0, 3) - mulk(x1, 3) + x2 - xm, 3);
        end else begin
            k2 = mulk(x1, 6) - mulk(xm, 2) - mulk(x0, 3) - x2;
            k3 = mulk(xm, 3) - mulk(x0, 6) + mulk(x1, 3);
            k4 = mulk(x0, 3) - mulk(x1, 3) + x2 - xm;
        end
    end

    // register the coefficients alongside their position and flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_top <= '0;
            for (int i = 0; i < NST; i++) c_low[i] <= '0;
            t_out <= '0;
            v_out <= 1'b0;
        end else begin
            c_top    <= k4;
            c_low[0] <= k1;
            c_low[1] <= k2;
            c_low[2] <= k3;
            t_out    <= t_in;
            v_out    <= v_in;
        end
    end
endmodule

// File: rtl/rsmp_horner.sv
// One nested-evaluation step: multiplies the partial value by the position,
// floors the fraction away and adds the selected coefficient. It registers
// the sum and carries the position, flag and coefficients to the next step.
module rsmp_horner
    import rsmp_pkg::*;
#(
    parameter int TW  = 16,
    parameter int AW  = 15,
    parameter int SEL = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [AW-1:0] h_in,
    input  logic signed [AW-1:0] c_in [NST],
    input  logic [TW-1:0]        t_in,
    input  logic                 v_in,
    output logic signed [AW-1:0] h_out,
    output logic signed [AW-1:0] c_out [NST],
    output logic [TW-1:0]        t_out,
    output logic                 v_out
);
    localparam int PW = AW + TW + 1;

    logic signed [AW-1:0] h_next;

    // floor(h * t / 2^TW) plus the coefficient of this step
    always_comb begin
        h_next = AW'((PW'(h_in) * PW'($signed({1'b0, t_in}))) >>> TW) + c_in[SEL];
    end

    // register the step result and carry the rest forward
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_out <= '0;
            for (int i = 0; i < NST; i++) c_out[i] <= '0;
            t_out <= '0;
            v_out <= 1'b0;
        end else begin
            h_out <= h_next;
            c_out <= c_in;
            t_out <= t_in;
            v_out <= v_in;
        end
    end
endmodule

// File: rtl/rsmp_out.sv
// Output stage: removes the common scale by signed division, which truncates
// toward zero. It clamps to the sample range and registers the result. The
// data register loads only with a valid flag and otherwise keeps its value.
module rsmp_out
    import rsmp_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = DW + 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [AW-1:0] h_in,
    input  logic                 v_in,
    output logic signed [DW-1:0] dout,
    output logic                 dout_valid
);
    localparam logic signed [AW-1:0] DEN  = AW'(SCALE);
    localparam logic signed [AW-1:0] YMAX = AW'(2 ** (DW - 1) - 1);
    localparam logic signed [AW-1:0] YMIN = AW'(-(2 ** (DW - 1)));

    logic signed [AW-1:0] q;
    logic signed [DW-1:0] y;

    // descale and clamp to the sample width
    always_comb begin
        q = h_in / DEN;
        if (q > YMAX)
            y = YMAX[DW-1:0];
        else if (q < YMIN)
            y = YMIN[DW-1:0];
        else
            y = q[DW-1:0];
    end

    // publish the value with its strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout       <= '0;
            dout_valid <= 1'b0;
        end else begin
            dout_valid <= v_in;
            if (v_in) dout <= y;
        end
    end
endmodule

// File: rtl/cubic_resampler.sv
// Cubic interpolating fractional resampler. The window, the phase
// accumulator and the coefficient combiner feed a chain of NST
// multiply-add steps and an output stage, five register levels in all.
// Assumes one sample per clock, step below one, and mode changed only in reset.
module cubic_resampler
    import rsmp_pkg::*;
#(
    parameter int DW = 8,
    parameter int TW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode,
    input  logic [TW-1:0]        step,
    input  logic signed [DW-1:0] din,
    output logic signed [DW-1:0] dout,
    output logic                 dout_valid
);
    localparam int AW = DW + 7;

    logic signed [DW-1:0] win [TAPS];
    logic                 full;
    logic [TW-1:0]        frac;
    logic                 over;

    logic signed [AW-1:0] hq [NST+1];
    logic signed [AW-1:0] cq [NST+1][NST];
    logic [TW-1:0]        tq [NST+1];
    logic                 vq [NST+1];

    rsmp_window #(.DW(DW)) u_window (
        .clk(clk), .rst_n(rst_n), .din(din), .win(win), .full(full)
    );

    rsmp_phase #(.TW(TW)) u_phase (
        .clk(clk), .rst_n(rst_n), .advance(full), .step(step),
        .frac(frac), .over(over)
    );

    rsmp_coef #(.DW(DW), .TW(TW), .AW(AW)) u_coef (
        .clk(clk), .rst_n(rst_n), .mode(mode), .win(win),
        .t_in(frac), .v_in(full && !over),
        .c_top(hq[0]), .c_low(cq[0]), .t_out(tq[0]), .v_out(vq[0])
    );

    for (genvar s = 0; s < NST; s++) begin : g_step
        rsmp_horner #(.TW(TW), .AW(AW), .SEL(NST - 1 - s)) u_step (
            .clk(clk), .rst_n(rst_n),
            .h_in(hq[s]), .c_in(cq[s]), .t_in(tq[s]), .v_in(vq[s]),
            .h_out(hq[s+1]), .c_out(cq[s+1]), .t_out(tq[s+1]), .v_out(vq[s+1])
        );
    end

    rsmp_out #(.DW(DW), .AW(AW)) u_out (
        .clk(clk), .rst_n(rst_n), .h_in(hq[NST]), .v_in(vq[NST]),
        .dout(dout), .dout_valid(dout_valid)
    );
endmodule

// File: rtl/rsmp_chk.sv
// Port-level checker for the cubic resampler, attached by bind. It keeps its
// own count of clocks since reset release to time its properties.
module rsmp_chk #(
    parameter int DW = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 mode,
    input logic signed [DW-1:0] dout,
    input logic                 dout_valid
);
    logic [4:0] cyc;

    // clocks seen since reset release, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)
            cyc <= '0;
        else if (cyc != 5'd31)
            cyc <= cyc + 1'b1;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!dout_valid && dout == '0));

    assert_no_early_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |-> cyc >= 5'd9);

    assert_single_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 5'd9 && !dout_valid) |=> dout_valid);

    assert_mode_fixed_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc != 5'd0) |-> $stable(mode));

    assert_hold_value_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc != 5'd0 && !dout_valid) |-> $stable(dout));
endmodule

bind cubic_resampler rsmp_chk #(.DW(DW)) i_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .dout(dout), .dout_valid(dout_valid)
);

// File: tb/test_cubic_resampler.sv
`timescale 1ns/1ps
module test_cubic_resampler;
    localparam int DW = 8;
    localparam int TW = 16;
    localparam longint ONE = 64'd1 << TW;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 mode = 1'b0;
    logic [TW-1:0]        step = '0;
    logic signed [DW-1:0] din = '0;
    logic signed [DW-1:0] dout;
    logic                 dout_valid;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 0;
    bit running = 0;

    // behavioural model state
    int     win[$];
    int     vqm[$];
    int     yqm[$];
    int     kqm[$];
    longint acc = 0;
    bit     mreset = 1;
    int     since_rst = 0;
    bit     seen_first = 0;
    int     exp_y = 0;

    always #4 clk = ~clk;

    cubic_resampler #(.DW(DW), .TW(TW)) i_cubic_resampler (
        .clk(clk), .rst_n(rst_n), .mode(mode), .step(step),
        .din(din), .dout(dout), .dout_valid(dout_valid)
    );

    task automatic chk(input bit ok, input string tag, input int got, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, expv);
        end
    endtask

    // kernel from the requirement text (R6, R7, R8, R9)
    function automatic int kernel(input int xm, input int x0, input int x1, input int x2,
                                  input longint tt, input bit md, output bit clipped);
        longint c1, c2, c3, c4, h, q;
        c1 = 6 * x0;
        if (md) begin
            c2 = 3 * (x1 - xm);
            c3 = 3 * (2 * xm - 5 * x0 + 4 * x1 - x2);
            c4 = 3 * (-xm + 3 * x0 - 3 * x1 + x2);
        end else begin
            c2 = -2 * xm - 3 * x0 + 6 * x1 - x2;
            c3 = 3 * xm - 6 * x0 + 3 * x1;
            c4 = -xm + 3 * x0 - 3 * x1 + x2;
        end
        h = c4;
        h = ((h * tt) >>> TW) + c3;
        h = ((h * tt) >>> TW) + c2;
        h = ((h * tt) >>> TW) + c1;
        q = h / 6;
        clipped = (q > 127) || (q < -128);
        if (q > 127) q = 127;
        if (q < -128) q = -128;
        return int'(q);
    endfunction

    // model: result from pre-edge state, then advance the state
    always @(posedge clk) begin : model
        int rv, ry;
        bit cl;
        if (!rst_n) begin
            win.delete(); vqm.delete(); yqm.delete(); kqm.delete();
            acc = 0; mreset = 1; since_rst = 0; seen_first = 0;
        end else begin
            mreset = 0;
            since_rst++;
            rv = 0; ry = 0; cl = 0;
            if (win.size() == 4 && acc < ONE) begin
                rv = 1;
                ry = kernel(win[0], win[1], win[2], win[3], acc, mode, cl);
            end
            vqm.push_back(rv); yqm.push_back(ry); kqm.push_back(int'(cl));
            if (vqm.size() > 5) begin
                void'(vqm.pop_front()); void'(yqm.pop_front()); void'(kqm.pop_front());
            end
            if (win.size() == 4) acc = (acc >= ONE) ? acc - ONE : acc + longint'(step);
            win.push_back(int'(din));
            if (win.size() > 4) void'(win.pop_front());
        end
    end

    // compare outputs away from the active edge
    always @(negedge clk) begin : compare
        bit ev;
        string tg;
        if (running) begin
            ev = (vqm.size() == 5) && (vqm[0] != 0);
            if (mreset) exp_y = 0;
            else if (ev) exp_y = yqm[0];
            tg = mreset ? "R1 strobe" : "R2 R3 R4 R5 strobe";
            chk(dout_valid == ev, tg, int'(dout_valid), int'(ev));
            if (mreset) tg = "R1 data";
            else if (!ev) tg = "R12 held data";
            else begin
                tg = mode ? "R7 R3 R8 data" : "R6 R3 R8 data";
                if (kqm[0] != 0) tg = {tg, " R9 clamp"};
                if (step == 0) tg = {tg, " R10 t=0"};
            end
            chk(int'(dout) == exp_y, tg, int'(dout), exp_y);
            if (!mreset && dout_valid && !seen_first) begin
                seen_first = 1;
                chk(since_rst == 9, "R2 first strobe edge", since_rst, 9);
            end
        end
    end

    // watchdog: a hung run counts as one failed check
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog got=%0d exp=%0d", cycles, 20000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic run(input int n, input int kind);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            case (kind)
                0: din = DW'(i * 7);
                2: din = ((i % 4) < 2) ? 8'sd127 : -8'sd128;
                3: begin
                    if (i % 10 == 0) step = TW'($urandom);
                    din = DW'($urandom);
                end
                default: din = DW'($urandom);
            endcase
        end
    endtask

    // mode is changed only inside reset (R11)
    task automatic do_reset(input bit md);
        @(posedge clk); #1;
        rst_n = 1'b0;
        mode  = md;
        repeat (3) begin @(posedge clk); #1; end
        rst_n = 1'b1;
    endtask

    initial begin
        running = 1;
        repeat (4) begin @(posedge clk); #1; end
        rst_n = 1'b1;
        step = '0;             run(60, 0);    // R10: exact sample at t = 0
        step = 16'h5000;       run(300, 1);   // R4 R6 mid-range step
        step = 16'h9c40;       do_reset(1); run(300, 1);  // R7 R11
        step = 16'h8000;       do_reset(0); run(120, 2);  // R9 exact-fit overshoot
        do_reset(1);           run(120, 2);               // R9 slope-matched overshoot
        step = 16'hffff;       do_reset(1); run(200, 1);  // R5 skip almost every other
        do_reset(0);           run(300, 3);               // R4 R5 step changing in flight
        repeat (6) @(posedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule